// File: doc/BRIEF.md
# Indexed Clock-Chip Register Port with Interrupt Flags

This block sits between a host bus and the time-keeping logic of a real-time clock. The host sees two byte addresses. A write to the even address selects one of 128 byte locations. An access to the odd address reads or writes the selected byte. Most locations are plain storage. Four of them are control and status registers, and each of these has its own write and read rules.

The calendar counter and the rate divider are outside this block. They send single-cycle strobes: update start, update end, alarm match and periodic tick. The block turns these strobes into flag bits in the status register and drives one level-sensitive interrupt. The settings of the two control registers are brought out so that the counter and the divider can follow them. A power-on reset loads defined values into the control registers. A separate warm reset clears only the enables and the flags.

Top module: `rtc_regport`

## Requirements
- R1: A write to the even address (`bus_addr`=0) stores `bus_wdata[6:0]` as the index, and bit 7 is dropped. A read of the even address returns 0xFF.
- R2: Indices 0–9 and 14–127 are plain bytes. A write at the odd address stores the data, and a read returns it.
- R3: Control register A is index 10. Its bit 7 (update busy) cannot be written. A write keeps that bit and replaces bits 6:0.
- R4: Control register B is index 11. A write to it with bit 7 (freeze) high clears bit 7 of register A, and the stored value has bit 4 (update-interrupt enable) forced to 0.
- R5: Writes to index 12 (status C) and index 13 (status D) have no effect.
- R6: A read of status C returns its current value. On the next clock it becomes 0x00, and `irq` falls unless an event arrives in the same cycle.
- R7: An update-end strobe clears bit 7 of A and always sets C bit 4. When B bit 4 is 1, it also sets C bit 7 and raises `irq`.
- R8: An alarm strobe sets C to include 0xA0 only when B bit 5 is 1. A periodic strobe sets C to include 0xC0 only when B bit 6 is 1. When its enable is 0, a strobe leaves C and `irq` unchanged.
- R9: An update-start strobe sets bit 7 of A unless B bit 7 (freeze) is 1.
- R10: After power-on reset, A=0x26, B=0x02, C=0x00, D=0x80 and `irq` is 0.
- R11: Warm reset clears B bits 6, 5 and 3, clears C to 0x00 and lowers `irq`. A and the other bits of B are kept.
- R12: `irq` stays high from the first flagged event until status C is read. An event in the same cycle as that read is kept in C and `irq` for the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, synchronous |
| warm_rst | input | 1 | Warm reset pulse: clears enables and flags |
| bus_cs | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = index port, 1 = data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| ev_update_start | input | 1 | Calendar update begins |
| ev_update_end | input | 1 | Calendar update finished |
| ev_alarm | input | 1 | Alarm compare matched |
| ev_periodic | input | 1 | Rate divider tick |
| ctrl_a | output | 8 | Current register A |
| ctrl_b | output | 8 | Current register B |
| irq | output | 1 | Level interrupt request |

## Verification
The risky collision is a read of status C in the same cycle that an update-end strobe arrives. The bench drives both at one clock. It checks that the read returns the old flags, that `irq` stays high, and that the next read of C returns the new flags. A second collision is an update-start strobe while register B is in freeze. This is judged through the update-busy bit in A, read at the data port.

// File: rtl/rtc_regport_pkg.sv
package rtc_regport_pkg;
   localparam int BYTE_W = 8;

   localparam int IX_CTRL_A = 10;
   localparam int IX_CTRL_B = 11;
   localparam int IX_STAT_C = 12;
   localparam int IX_STAT_D = 13;

   localparam logic [BYTE_W-1:0] A_POWERUP = 8'h26;
   localparam logic [BYTE_W-1:0] B_POWERUP = 8'h02;
   localparam logic [BYTE_W-1:0] D_FIXED   = 8'h80;

   localparam int A_BUSY   = 7;
   localparam int B_FREEZE = 7;
   localparam int B_PER_EN = 6;
   localparam int B_ALM_EN = 5;
   localparam int B_UPD_EN = 4;
   localparam int B_SQW_EN = 3;

   localparam logic [BYTE_W-1:0] C_ANY = 8'h80;
   localparam logic [BYTE_W-1:0] C_PER = 8'h40;
   localparam logic [BYTE_W-1:0] C_ALM = 8'h20;
   localparam logic [BYTE_W-1:0] C_UPD = 8'h10;

   typedef enum logic [1:0] {
      SEL_A = 2'd0,
      SEL_B = 2'd1,
      SEL_C = 2'd2,
      SEL_D = 2'd3
   } ctrl_sel_e;
endpackage

// File: rtl/rtc_index_latch.sv
module rtc_index_latch #(
   parameter int IDX_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [7:0]       wdata,
   output logic [IDX_W-1:0] index
);
   generate
      if (IDX_W < 4 || IDX_W > 7) begin : g_bad_width
         $error("rtc_index_latch: IDX_W must be 4..7");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) index <= '0;
      else if (load) index <= wdata[IDX_W-1:0];
   end

   p_index_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> index == $past(wdata[IDX_W-1:0]));
endmodule

// File: rtl/rtc_byte_store.sv
module rtc_byte_store #(
   parameter int IDX_W       = 7,
   parameter bit CLEAR_STORE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] addr,
   input  logic [7:0]       wdata,
   output logic [7:0]       rdata
);
   localparam int DEPTH = 1 << IDX_W;

   logic [7:0] mem [DEPTH];

   generate
      if (CLEAR_STORE) begin : g_cleared
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we) begin
               mem[addr] <= wdata;
            end
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (we) mem[addr] <= wdata;
         end
      end
   endgenerate

   assign rdata = mem[addr];

   p_store_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> rdata == $past(wdata) || addr != $past(addr));
endmodule

// File: rtl/rtc_ctrl_regs.sv
module rtc_ctrl_regs
   import rtc_regport_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        warm_rst,
   input  logic        wr,
   input  logic        rd,
   input  ctrl_sel_e   sel,
   input  logic [7:0]  wdata,
   input  logic        ev_update_start,
   input  logic        ev_update_end,
   input  logic        ev_alarm,
   input  logic        ev_periodic,
   output logic [7:0]  rdata,
   output logic [7:0]  reg_a,
   output logic [7:0]  reg_b,
   output logic [7:0]  reg_c,
   output logic        irq
);
   logic [7:0] a_n, b_n, c_n, ev_bits;
   logic       irq_n, raise, clr_c;
   logic       wr_a, wr_b, wr_c, wr_d;

   assign wr_a  = wr && sel == SEL_A;
   assign wr_b  = wr && sel == SEL_B;
   assign wr_c  = wr && sel == SEL_C;
   assign wr_d  = wr && sel == SEL_D;
   assign clr_c = rd && sel == SEL_C;

   always_comb begin
      ev_bits = '0;
      raise   = 1'b0;
      if (ev_update_end) begin
         ev_bits |= C_UPD;
         if (reg_b[B_UPD_EN]) begin
            ev_bits |= C_ANY;
            raise    = 1'b1;
         end
      end
      if (ev_alarm && reg_b[B_ALM_EN]) begin
         ev_bits |= C_ANY | C_ALM;
         raise    = 1'b1;
      end
      if (ev_periodic && reg_b[B_PER_EN]) begin
         ev_bits |= C_ANY | C_PER;
         raise    = 1'b1;
      end
   end

   always_comb begin
      a_n = reg_a;
      if (wr_a) a_n = {reg_a[A_BUSY], wdata[6:0]};
      if (ev_update_start && !reg_b[B_FREEZE]) a_n[A_BUSY] = 1'b1;
      if (ev_update_end) a_n[A_BUSY] = 1'b0;
      if (wr_b && wdata[B_FREEZE]) a_n[A_BUSY] = 1'b0;
   end

   always_comb begin
      b_n = reg_b;
      if (wr_b) begin
         b_n = wdata;
         if (wdata[B_FREEZE]) b_n[B_UPD_EN] = 1'b0;
      end
      if (warm_rst) begin
         b_n[B_PER_EN] = 1'b0;
         b_n[B_ALM_EN] = 1'b0;
         b_n[B_SQW_EN] = 1'b0;
      end
   end

   always_comb begin
      c_n   = (clr_c ? 8'h00 : reg_c) | ev_bits;
      irq_n = (irq && !clr_c) || raise;
      if (warm_rst) begin
         c_n   = c_n & ~(C_ANY | C_PER | C_ALM | C_UPD);
         irq_n = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_a <= A_POWERUP;
         reg_b <= B_POWERUP;
         reg_c <= '0;
         irq   <= 1'b0;
      end else begin
         reg_a <= a_n;
         reg_b <= b_n;
         reg_c <= c_n;
         irq   <= irq_n;
      end
   end

   always_comb begin
      unique case (sel)
         SEL_A:   rdata = reg_a;
         SEL_B:   rdata = reg_b;
         SEL_C:   rdata = reg_c;
         default: rdata = D_FIXED;
      endcase
   end

   logic any_ev;
   assign any_ev = ev_update_start || ev_update_end || ev_alarm || ev_periodic;

   p_busy_readonly_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_a && !any_ev |=> reg_a[A_BUSY] == $past(reg_a[A_BUSY]));
   p_freeze_masks_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_b && wdata[B_FREEZE] |=> !reg_b[B_UPD_EN] && !reg_a[A_BUSY]);
   p_status_nowrite_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_c || wr_d) && !any_ev && !warm_rst |=> $stable(reg_c) && $stable(irq));
   p_read_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clr_c && !any_ev |=> reg_c == 8'h00 && !irq);
   p_upd_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ev_update_end && !warm_rst |=> reg_c[4] && !reg_a[A_BUSY]);
   p_warm_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      warm_rst |=> reg_c == 8'h00 && !irq && !reg_b[B_PER_EN] && !reg_b[B_ALM_EN] && !reg_b[B_SQW_EN]);
   p_irq_holds_r12: assert property (@(posedge clk) disable iff (!rst_n)
      irq && !clr_c && !warm_rst |=> irq);
endmodule

// File: rtl/rtc_regport.sv
module rtc_regport
   import rtc_regport_pkg::*;
#(
   parameter int IDX_W       = 7,
   parameter bit CLEAR_STORE = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       warm_rst,
   input  logic       bus_cs,
   input  logic       bus_we,
   input  logic       bus_addr,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   input  logic       ev_update_start,
   input  logic       ev_update_end,
   input  logic       ev_alarm,
   input  logic       ev_periodic,
   output logic [7:0] ctrl_a,
   output logic [7:0] ctrl_b,
   output logic       irq
);
   generate
      if (IDX_W < 4 || IDX_W > 7) begin : g_bad_idx
         $error("rtc_regport: IDX_W must be 4..7");
      end
   endgenerate

   logic [IDX_W-1:0] index;
   logic             idx_load, data_wr, data_rd, ctrl_hit;
   logic [7:0]       ctrl_rdata, store_rdata, status_c;
   ctrl_sel_e        sel;

   assign idx_load = bus_cs && bus_we && !bus_addr;
   assign data_wr  = bus_cs && bus_we && bus_addr;
   assign data_rd  = bus_cs && !bus_we && bus_addr;
   assign ctrl_hit = int'(index) >= IX_CTRL_A && int'(index) <= IX_STAT_D;
   assign sel      = ctrl_sel_e'(2'(int'(index) - IX_CTRL_A));

   rtc_index_latch #(.IDX_W(IDX_W)) u_index (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (idx_load),
      .wdata (bus_wdata),
      .index (index)
   );

   rtc_byte_store #(.IDX_W(IDX_W), .CLEAR_STORE(CLEAR_STORE)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (data_wr && !ctrl_hit),
      .addr  (index),
      .wdata (bus_wdata),
      .rdata (store_rdata)
   );

   rtc_ctrl_regs u_ctrl (
      .clk             (clk),
      .rst_n           (rst_n),
      .warm_rst        (warm_rst),
      .wr              (data_wr && ctrl_hit),
      .rd              (data_rd && ctrl_hit),
      .sel             (sel),
      .wdata           (bus_wdata),
      .ev_update_start (ev_update_start),
      .ev_update_end   (ev_update_end),
      .ev_alarm        (ev_alarm),
      .ev_periodic     (ev_periodic),
      .rdata           (ctrl_rdata),
      .reg_a           (ctrl_a),
      .reg_b           (ctrl_b),
      .reg_c           (status_c),
      .irq             (irq)
   );

   always_comb begin
      if (!bus_addr)     bus_rdata = 8'hFF;
      else if (ctrl_hit) bus_rdata = ctrl_rdata;
      else               bus_rdata = store_rdata;
   end

   p_irq_has_flag_r12: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> status_c[7]);
endmodule

// File: tb/test_rtc_regport.sv
module test_rtc_regport;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic warm_rst = 1'b0;
   logic bus_cs = 1'b0, bus_we = 1'b0, bus_addr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic ev_us = 1'b0, ev_ue = 1'b0, ev_al = 1'b0, ev_pe = 1'b0;
   logic [7:0] ctrl_a, ctrl_b;
   logic irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   rtc_regport i_rtc_regport (
      .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst),
      .bus_cs(bus_cs), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ev_update_start(ev_us), .ev_update_end(ev_ue),
      .ev_alarm(ev_al), .ev_periodic(ev_pe),
      .ctrl_a(ctrl_a), .ctrl_b(ctrl_b), .irq(irq)
   );

   task automatic check(string req, logic [7:0] got, logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
      end
   endtask

   task automatic wr(logic a, logic [7:0] d);
      @(negedge clk);
      bus_cs = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_cs = 0; bus_we = 0;
   endtask

   task automatic rd(logic a, output logic [7:0] d);
      @(negedge clk);
      bus_cs = 1; bus_we = 0; bus_addr = a;
      #2 d = bus_rdata;
      @(negedge clk);
      bus_cs = 0;
   endtask

   task automatic put(logic [6:0] ix, logic [7:0] d);
      wr(0, {1'b0, ix}); wr(1, d);
   endtask

   task automatic get(logic [6:0] ix, output logic [7:0] d);
      wr(0, {1'b0, ix}); rd(1, d);
   endtask

   task automatic strobe(int which);
      @(negedge clk);
      case (which)
         0: ev_us = 1;
         1: ev_ue = 1;
         2: ev_al = 1;
         default: ev_pe = 1;
      endcase
      @(negedge clk);
      ev_us = 0; ev_ue = 0; ev_al = 0; ev_pe = 0;
   endtask

   task automatic t_powerup;
      logic [7:0] v;
      get(10, v); check("R10 A", v, 8'h26);
      get(11, v); check("R10 B", v, 8'h02);
      get(12, v); check("R10 C", v, 8'h00);
      get(13, v); check("R10 D", v, 8'h80);
      check("R10 irq", {7'b0, irq}, 8'h00);
   endtask

   task automatic t_index_store;
      logic [7:0] v;
      rd(0, v); check("R1 even read", v, 8'hFF);
      put(7'h05, 8'h3C); put(7'h7F, 8'hA5); put(7'h0E, 8'h11);
      get(7'h7F, v); check("R2 idx127", v, 8'hA5);
      get(7'h0E, v); check("R2 idx14", v, 8'h11);
      wr(0, 8'h85); rd(1, v); check("R1 bit7 dropped", v, 8'h3C);
   endtask

   task automatic t_reg_a;
      logic [7:0] v;
      strobe(0);
      get(10, v); check("R9 busy set", v, 8'hA6);
      put(10, 8'h00); get(10, v); check("R3 busy kept", v, 8'h80);
      put(10, 8'h2F); get(10, v); check("R3 low bits", v, 8'hAF);
      strobe(1);
      get(10, v); check("R7 busy cleared", v, 8'h2F);
      check("R7 no irq w/o enable", {7'b0, irq}, 8'h00);
      get(12, v); check("R7 UF only", v, 8'h10);
      get(12, v); check("R6 cleared", v, 8'h00);
   endtask

   task automatic t_freeze;
      logic [7:0] v;
      strobe(0);
      put(11, 8'h92);
      get(11, v); check("R4 UIE forced 0", v, 8'h82);
      get(10, v); check("R4 busy cleared", v, 8'h2F);
      strobe(0);
      get(10, v); check("R9 frozen no busy", v, 8'h2F);
      put(11, 8'h12);
      strobe(1);
      check("R7 irq raised", {7'b0, irq}, 8'h01);
      get(12, v); check("R7 IRQF+UF", v, 8'h90);
      check("R6 irq low", {7'b0, irq}, 8'h00);
   endtask

   task automatic t_alarm_periodic;
      logic [7:0] v;
      put(11, 8'h22);
      strobe(2);
      check("R8 alarm irq", {7'b0, irq}, 8'h01);
      get(12, v); check("R8 alarm flags", v, 8'hA0);
      put(11, 8'h02);
      strobe(2); strobe(3);
      check("R8 disabled irq", {7'b0, irq}, 8'h00);
      get(12, v); check("R8 disabled flags", v, 8'h00);
      put(11, 8'h42);
      strobe(3);
      get(12, v); check("R8 periodic flags", v, 8'hC0);
   endtask

   task automatic t_status_ro;
      logic [7:0] v;
      put(12, 8'hFF); get(12, v); check("R5 C ignored", v, 8'h00);
      check("R5 irq unchanged", {7'b0, irq}, 8'h00);
      put(13, 8'h00); get(13, v); check("R5 D ignored", v, 8'h80);
   endtask

   task automatic t_collide;
      logic [7:0] v;
      put(11, 8'h12);
      strobe(1);
      repeat (4) @(negedge clk);
      check("R12 irq held", {7'b0, irq}, 8'h01);
      wr(0, 8'h0C);
      @(negedge clk);
      bus_cs = 1; bus_we = 0; bus_addr = 1; ev_ue = 1;
      #2 v = bus_rdata;
      @(negedge clk);
      bus_cs = 0; ev_ue = 0;
      check("R12 read returns old", v, 8'h90);
      check("R12 irq kept", {7'b0, irq}, 8'h01);
      get(12, v); check("R12 new event kept", v, 8'h90);
      check("R12 irq low after", {7'b0, irq}, 8'h00);
   endtask

   task automatic t_warm;
      logic [7:0] v;
      put(11, 8'h7E);
      strobe(3);
      check("R11 irq before", {7'b0, irq}, 8'h01);
      @(negedge clk); warm_rst = 1;
      @(negedge clk); warm_rst = 0;
      check("R11 irq low", {7'b0, irq}, 8'h00);
      get(11, v); check("R11 B masked", v, 8'h16);
      get(12, v); check("R11 C cleared", v, 8'h00);
      get(10, v); check("R11 A kept", v, 8'h2F);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_powerup();
      t_index_store();
      t_reg_a();
      t_freeze();
      t_alarm_periodic();
      t_status_ro();
      t_collide();
      t_warm();
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #(20 * 20000);
      if (!done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule